// File: doc/BRIEF.md
# MSI Vector Interrupt Aggregator

This block gathers 32 message-signalled interrupt vectors into eight interrupt groups, each with a level output toward the interrupt controller. Remote devices ring a vector by writing its number to a fixed doorbell offset on an inbound write port. The vectors are interleaved across the groups: the low three bits of the vector choose the group and the next two bits choose the bit inside it. Each group therefore holds four vectors spaced eight apart.

Software uses a simple register bus to read the pending bits of each group and to clear them by writing ones. It changes each group's enable mask only through separate set and clear registers. When a group's output has fired, it cannot fire again until software writes that group's code to a shared end-of-interrupt register. Four legacy level interrupt lines have their own pending flag, enable and output, and they use the same end-of-interrupt register with their own codes.

Top module: `msi_irq_agg`

## Requirements
- R1: A `db_wr` with `db_addr` = 0x054 takes the vector from `db_data[4:0]` and ignores `db_data[31:5]`. Vector v sets bit v[4:3] of group v[2:0]. A doorbell write to any other address changes no status.
- R2: Group g's status reads at 0x104 + 0x10·g. It returns the pending bits in [3:0] whether or not they are enabled, and bits [31:4] read as 0. Read data appears on `reg_rdata` in the cycle after the `reg_rd` cycle.
- R3: Writing a 1 to a status bit clears it. Status bits written with 0 keep their value.
- R4: For group g, a 1 written to 0x108 + 0x10·g sets that enable bit and a 1 written to 0x10C + 0x10·g clears it. Writing 0 to either changes nothing. Reading either address returns the enable mask.
- R5: `msi_irq[g]` is registered. It goes high one cycle after (status AND enable) of group g becomes nonzero, provided the group is armed. It stays high while that AND stays nonzero.
- R6: After `msi_irq[g]` has been high, the group is disarmed. Once the AND drops to zero, new pending bits do not raise the output again. Writing g+4 to the end-of-interrupt register at 0x050 re-arms the group, and the output then rises again if the AND is still nonzero.
- R7: End-of-interrupt codes are exact. Code k (0..3) re-arms legacy line k, code g+4 re-arms group g, and any other value leaves a source disarmed.
- R8: If a doorbell sets a status bit in the same cycle that a software write clears it, the bit stays set.
- R9: While `intx_in[k]` is high, it sets pending bit 0 of legacy line k. That bit reads at 0x184 + 0x10·k and is cleared by writing 1, but stays set while the line is still high. The line's enable is set at 0x188 + 0x10·k and cleared at 0x18C + 0x10·k. `intx_irq[k]` follows the arming rules of R5 and R6 with code k.
- R10: After reset, all status and enable bits are 0, every output is low and every source is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register bus write strobe |
| reg_rd | input | 1 | Register bus read strobe |
| reg_addr | input | 12 | Register bus byte address |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| db_wr | input | 1 | Decoded inbound doorbell write strobe |
| db_addr | input | 12 | Inbound write offset |
| db_data | input | 32 | Inbound write data carrying the vector number |
| intx_in | input | 4 | Legacy level interrupt lines |
| msi_irq | output | 8 | Per-group level interrupt outputs |
| intx_irq | output | 4 | Per-line legacy interrupt outputs |

## Verification
An inbound doorbell can land in the same cycle as a software write-one-to-clear aimed at the same status register. The bench drives both strobes together on one clock edge, once in a directed case on the same bit and many times in the random phase with random clear masks. It then judges the result by reading status back: a bench model that applies the clear first and the doorbell set second must match every bit. The end-of-interrupt re-arm is also checked against new pending bits that arrive while the source is disarmed.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned AGG_AW        = 12;
  localparam int unsigned AGG_DW        = 32;
  localparam int unsigned AGG_STRIDE    = 'h10;
  localparam int unsigned AGG_EOI_A     = 'h050;
  localparam int unsigned AGG_DB_A      = 'h054;
  localparam int unsigned AGG_GRP_ST_A  = 'h104;
  localparam int unsigned AGG_GRP_ES_A  = 'h108;
  localparam int unsigned AGG_GRP_EC_A  = 'h10C;
  localparam int unsigned AGG_LEG_ST_A  = 'h184;
  localparam int unsigned AGG_LEG_ES_A  = 'h188;
  localparam int unsigned AGG_LEG_EC_A  = 'h18C;
endpackage

// File: rtl/msi_db_dec.sv
module msi_db_dec #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned NUM_GRP = 8,
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 32,
  parameter int unsigned DB_A    = 'h054,
  localparam int unsigned GW     = NUM_VEC / NUM_GRP,
  localparam int unsigned VW     = $clog2(NUM_VEC)
) (
  input  logic                         db_wr,
  input  logic [AW-1:0]                db_addr,
  input  logic [DW-1:0]                db_data,
  output logic [NUM_GRP-1:0][GW-1:0]   grp_set
);
  logic          hit;
  logic [VW-1:0] vec;

  assign hit = db_wr && (db_addr == AW'(DB_A));
  assign vec = db_data[VW-1:0];

  // group = vector modulo group count, bit = vector / group count
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar b = 0; b < GW; b++) begin : g_bit
      assign grp_set[g][b] = hit && (vec == VW'(b * NUM_GRP + g));
    end
  end
endmodule

// File: rtl/msi_src_slice.sv
module msi_src_slice #(
  parameter int unsigned W        = 4,
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned ST_A     = 'h104,
  parameter int unsigned ES_A     = 'h108,
  parameter int unsigned EC_A     = 'h10C,
  parameter int unsigned EOI_A    = 'h050,
  parameter int unsigned EOI_CODE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  set_bits,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [W-1:0]  status,
  output logic [W-1:0]  enable,
  output logic          irq
);
  logic [W-1:0] clr_m, en_set_m, en_clr_m;
  logic         pending, eoi_hit, held;

  always_comb begin
    clr_m    = (wr_en && wr_addr == AW'(ST_A)) ? wr_data[W-1:0] : '0;
    en_set_m = (wr_en && wr_addr == AW'(ES_A)) ? wr_data[W-1:0] : '0;
    en_clr_m = (wr_en && wr_addr == AW'(EC_A)) ? wr_data[W-1:0] : '0;
    eoi_hit  = wr_en && wr_addr == AW'(EOI_A) && wr_data == DW'(EOI_CODE);
    pending  = |(status & enable);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      held   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_m) | set_bits;   // set wins over clear
      enable <= (enable | en_set_m) & ~en_clr_m;
      irq    <= pending && (irq || !held);
      held   <= eoi_hit ? 1'b0 : (held || irq);
    end
  end
endmodule

// File: rtl/msi_rd_mux.sv
module msi_rd_mux #(
  parameter int unsigned NUM_GRP = 8,
  parameter int unsigned GW      = 4,
  parameter int unsigned NUM_LEG = 4,
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 32,
  parameter int unsigned STRIDE  = 'h10,
  parameter int unsigned G_ST_A  = 'h104,
  parameter int unsigned G_ES_A  = 'h108,
  parameter int unsigned G_EC_A  = 'h10C,
  parameter int unsigned L_ST_A  = 'h184,
  parameter int unsigned L_ES_A  = 'h188,
  parameter int unsigned L_EC_A  = 'h18C
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [AW-1:0]               rd_addr,
  input  logic [NUM_GRP-1:0][GW-1:0]  grp_status,
  input  logic [NUM_GRP-1:0][GW-1:0]  grp_enable,
  input  logic [NUM_LEG-1:0]          leg_status,
  input  logic [NUM_LEG-1:0]          leg_enable,
  output logic [DW-1:0]               rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (rd_addr == AW'(G_ST_A + g * STRIDE))
        sel = DW'(grp_status[g]);
      if (rd_addr == AW'(G_ES_A + g * STRIDE) || rd_addr == AW'(G_EC_A + g * STRIDE))
        sel = DW'(grp_enable[g]);
    end
    for (int k = 0; k < NUM_LEG; k++) begin
      if (rd_addr == AW'(L_ST_A + k * STRIDE))
        sel = DW'(leg_status[k]);
      if (rd_addr == AW'(L_ES_A + k * STRIDE) || rd_addr == AW'(L_EC_A + k * STRIDE))
        sel = DW'(leg_enable[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned NUM_GRP = 8,
  parameter int unsigned NUM_LEG = 4,
  parameter int unsigned AW      = AGG_AW,
  parameter int unsigned DW      = AGG_DW,
  localparam int unsigned GW     = NUM_VEC / NUM_GRP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               db_wr,
  input  logic [AW-1:0]      db_addr,
  input  logic [DW-1:0]      db_data,
  input  logic [NUM_LEG-1:0] intx_in,
  output logic [NUM_GRP-1:0] msi_irq,
  output logic [NUM_LEG-1:0] intx_irq
);
  logic [NUM_GRP-1:0][GW-1:0] grp_set, grp_status, grp_enable;
  logic [NUM_LEG-1:0]         leg_status, leg_enable;

  msi_db_dec #(
    .NUM_VEC(NUM_VEC), .NUM_GRP(NUM_GRP), .AW(AW), .DW(DW), .DB_A(AGG_DB_A)
  ) u_dec (
    .db_wr(db_wr), .db_addr(db_addr), .db_data(db_data), .grp_set(grp_set)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_msi
    msi_src_slice #(
      .W(GW), .AW(AW), .DW(DW),
      .ST_A(AGG_GRP_ST_A + g * AGG_STRIDE),
      .ES_A(AGG_GRP_ES_A + g * AGG_STRIDE),
      .EC_A(AGG_GRP_EC_A + g * AGG_STRIDE),
      .EOI_A(AGG_EOI_A), .EOI_CODE(NUM_LEG + g)
    ) u_slice (
      .clk(clk), .rst(rst), .set_bits(grp_set[g]),
      .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .status(grp_status[g]), .enable(grp_enable[g]), .irq(msi_irq[g])
    );
  end

  for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
    msi_src_slice #(
      .W(1), .AW(AW), .DW(DW),
      .ST_A(AGG_LEG_ST_A + k * AGG_STRIDE),
      .ES_A(AGG_LEG_ES_A + k * AGG_STRIDE),
      .EC_A(AGG_LEG_EC_A + k * AGG_STRIDE),
      .EOI_A(AGG_EOI_A), .EOI_CODE(k)
    ) u_slice (
      .clk(clk), .rst(rst), .set_bits(intx_in[k]),
      .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .status(leg_status[k:k]), .enable(leg_enable[k:k]), .irq(intx_irq[k])
    );
  end

  msi_rd_mux #(
    .NUM_GRP(NUM_GRP), .GW(GW), .NUM_LEG(NUM_LEG), .AW(AW), .DW(DW),
    .STRIDE(AGG_STRIDE),
    .G_ST_A(AGG_GRP_ST_A), .G_ES_A(AGG_GRP_ES_A), .G_EC_A(AGG_GRP_EC_A),
    .L_ST_A(AGG_LEG_ST_A), .L_ES_A(AGG_LEG_ES_A), .L_EC_A(AGG_LEG_EC_A)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(reg_rd), .rd_addr(reg_addr),
    .grp_status(grp_status), .grp_enable(grp_enable),
    .leg_status(leg_status), .leg_enable(leg_enable), .rdata(reg_rdata)
  );
endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned NUM_GRP = 8,
  parameter int unsigned NUM_LEG = 4,
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 32,
  localparam int unsigned GW     = NUM_VEC / NUM_GRP,
  localparam int unsigned VW     = $clog2(NUM_VEC)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        reg_wr,
  input logic [DW-1:0]               reg_rdata,
  input logic                        db_wr,
  input logic [AW-1:0]               db_addr,
  input logic [DW-1:0]               db_data,
  input logic [NUM_GRP-1:0]          msi_irq,
  input logic [NUM_LEG-1:0]          intx_irq,
  input logic [NUM_GRP-1:0][GW-1:0]  grp_status,
  input logic [NUM_GRP-1:0][GW-1:0]  grp_enable,
  input logic [NUM_LEG-1:0]          leg_status,
  input logic [NUM_LEG-1:0]          leg_enable
);
  // R1 and R8: a decoded doorbell always leaves its bit set, even against a clear
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    p_vec_sets_bit_r1: assert property (@(posedge clk) disable iff (rst)
      (db_wr && db_addr == AW'('h054) && db_data[VW-1:0] == VW'(v))
      |=> grp_status[v % NUM_GRP][v / NUM_GRP]);
  end

  p_rdata_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DW-1:GW] == '0);

  p_en_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(grp_enable) && $stable(leg_enable));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    p_irq_rise_pending_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(msi_irq[g]) |-> $past(|(grp_status[g] & grp_enable[g])));
  end

  for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
    p_intx_rise_pending_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(intx_irq[k]) |-> $past(leg_status[k] && leg_enable[k]));
  end
endmodule

bind msi_irq_agg msi_agg_chk #(
  .NUM_VEC(NUM_VEC), .NUM_GRP(NUM_GRP), .NUM_LEG(NUM_LEG), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .db_wr(db_wr), .db_addr(db_addr), .db_data(db_data),
  .msi_irq(msi_irq), .intx_irq(intx_irq),
  .grp_status(grp_status), .grp_enable(grp_enable),
  .leg_status(leg_status), .leg_enable(leg_enable)
);

// File: tb/sim_msi_irq_agg.sv
module sim_msi_irq_agg;
  localparam int NG = 8, NL = 4, AW = 12, DW = 32;

  logic          clk = 1'b0, rst = 1'b1;
  logic          reg_wr = 0, reg_rd = 0, db_wr = 0;
  logic [AW-1:0] reg_addr = '0, db_addr = '0;
  logic [DW-1:0] reg_wdata = '0, db_data = '0;
  logic [DW-1:0] reg_rdata;
  logic [NL-1:0] intx_in = '0, intx_irq;
  logic [NG-1:0] msi_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] exp_st [NG];
  logic [3:0] exp_en [NG];

  always #2 clk = ~clk;

  msi_irq_agg u0 (.*);

  function automatic logic [AW-1:0] st_a(int g); return AW'('h104 + 16 * g); endfunction
  function automatic logic [AW-1:0] es_a(int g); return AW'('h108 + 16 * g); endfunction
  function automatic logic [AW-1:0] ec_a(int g); return AW'('h10C + 16 * g); endfunction
  function automatic logic [AW-1:0] lst_a(int k); return AW'('h184 + 16 * k); endfunction
  function automatic logic [AW-1:0] les_a(int k); return AW'('h188 + 16 * k); endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic ring(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); db_wr = 1; db_addr = a; db_data = d;
    @(negedge clk); db_wr = 0;
  endtask

  task automatic ring_and_clear(logic [DW-1:0] d, logic [AW-1:0] a, logic [DW-1:0] m);
    @(negedge clk); db_wr = 1; db_addr = 'h054; db_data = d;
    reg_wr = 1; reg_addr = a; reg_wdata = m;
    @(negedge clk); db_wr = 0; reg_wr = 0;
  endtask

  task automatic pulse_intx(int k);
    @(negedge clk); intx_in[k] = 1'b1;
    @(negedge clk); intx_in[k] = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int unsigned seed;
    seed = $urandom(32'h5EED_0A61);
    idle(3); rst = 0; idle(1);

    // R10 reset state
    bus_rd(st_a(0), d);  check("R10 status", d, 0);
    bus_rd(es_a(3), d);  check("R10 enable", d, 0);
    check("R10 msi_irq", DW'(msi_irq), 0);
    check("R10 intx_irq", DW'(intx_irq), 0);

    // R1 mapping: vector 13 -> group 5, bit 1; high data bits ignored
    ring('h054, 32'hFFFF_FFE0 | 13);
    bus_rd(st_a(5), d);  check("R1 vec13 group5", d, 32'h2);
    ring('h058, 0);      // wrong offset
    bus_rd(st_a(0), d);  check("R1 wrong offset ignored", d, 0);
    // R2 pending shown while disabled, no irq
    check("R2 no irq while disabled", DW'(msi_irq), 0);

    // R4 enable set/clear semantics
    bus_wr(es_a(5), 32'h2);
    bus_wr(es_a(5), 32'h0);
    bus_rd(es_a(5), d);  check("R4 enable via set addr", d, 32'h2);
    bus_rd(ec_a(5), d);  check("R4 enable via clr addr", d, 32'h2);
    idle(1);
    check("R5 irq group5 high", DW'(msi_irq), 32'h20);

    // R3 write of zero keeps status
    bus_wr(st_a(5), 32'h0);
    bus_rd(st_a(5), d);  check("R3 zero write keeps bit", d, 32'h2);

    // R8 doorbell against clear in the same cycle
    ring_and_clear(13, st_a(5), 32'h2);
    bus_rd(st_a(5), d);  check("R8 doorbell wins", d, 32'h2);

    // R6 disarm after firing, R7 exact codes
    bus_wr(st_a(5), 32'h2); idle(2);
    check("R3 W1C drops irq", DW'(msi_irq), 0);
    ring('h054, 13); idle(2);
    check("R6 held low until EOI", DW'(msi_irq), 0);
    bus_wr('h050, 3); idle(2);
    check("R7 wrong EOI code", DW'(msi_irq), 0);
    bus_wr('h050, 9); idle(2);
    check("R6 EOI rearms", DW'(msi_irq), 32'h20);

    // R9 legacy line 2
    bus_wr(les_a(2), 1);
    pulse_intx(2); idle(1);
    check("R9 intx irq", DW'(intx_irq), 32'h4);
    bus_rd(lst_a(2), d); check("R9 intx status", d, 1);
    bus_wr(lst_a(2), 1); idle(2);
    check("R9 intx cleared", DW'(intx_irq), 0);
    pulse_intx(2); idle(2);
    check("R9 intx held", DW'(intx_irq), 0);
    bus_wr('h050, 2); idle(2);
    check("R9 intx EOI rearm", DW'(intx_irq), 32'h4);

    // clean slate for random phase
    for (int g = 0; g < NG; g++) begin
      bus_wr(st_a(g), 32'hF); bus_wr(ec_a(g), 32'hF);
      exp_st[g] = 0; exp_en[g] = 0;
    end

    for (int i = 0; i < 400; i++) begin
      int op, g, v;
      logic [DW-1:0] m;
      op = int'($urandom % 5); g = int'($urandom % NG); v = int'($urandom % 32);
      m = {$urandom} & 32'hF;
      case (op)
        0: begin ring('h054, ($urandom & 32'hFFFF_FFE0) | v); exp_st[v % 8][v / 8] = 1; end
        1: begin bus_wr(st_a(g), m | ($urandom & 32'hFFFF_FFF0)); exp_st[g] &= ~m[3:0]; end
        2: begin bus_wr(es_a(g), m); exp_en[g] |= m[3:0]; end
        3: begin bus_wr(ec_a(g), m); exp_en[g] &= ~m[3:0]; end
        default: begin
          ring_and_clear(v, st_a(v % 8), m);
          exp_st[v % 8] &= ~m[3:0];
          exp_st[v % 8][v / 8] = 1;
        end
      endcase
      if (i % 40 == 39) begin
        for (int q = 0; q < NG; q++) begin
          bus_rd(st_a(q), d); check("R1 R3 R8 random status", d, DW'(exp_st[q]));
          bus_rd(es_a(q), d); check("R4 random enable", d, DW'(exp_en[q]));
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule